// File: doc/BRIEF.md
# Oldest-First Out-of-Order Issue Queue

This block holds renamed instructions between rename and execute in a small out-of-order core shared by two threads. Each incoming instruction carries a thread id, an 8-bit sequence number, a 2-bit operation class, two physical source tags and one physical destination tag. An entry waits until both of its sources have been produced. Non-speculative entries also wait for a release from the commit side, and memory-class entries wait for a go from an external memory-ordering unit. Once an entry is ready it competes for one of the issue slots.

Candidates are grouped by operation class. For each class the oldest ready candidate is found first, and then the oldest of these class heads wins the slot. This is repeated once for each slot, so slot 0 always carries the oldest ready entry. Age is taken from the wrap-aware difference of the sequence numbers. Each entry moves through three states: `ST_FREE`, `ST_WAIT` and `ST_ISSUED`. The transitions are:
- INSERT: `ST_FREE` to `ST_WAIT`.
- SELECT: `ST_WAIT` to `ST_ISSUED`.
- RESCHEDULE: `ST_ISSUED` to `ST_WAIT`.
- KILL: any occupied state to `ST_FREE`, caused by a squash or a commit.

An issued entry keeps its slot and its thread's occupancy until it is committed or squashed.

A register scoreboard holds one ready bit for each physical register, 192 of them, with integer tags below 96 and floating-point tags from 96. A wakeup sets the bit. Inserting a new producer of the register clears it.

Top module: `ooo_issue_queue`

## Requirements
- R1: After reset the queue is empty: `in_rdy` is 1, `q_full` is 0 and no issue slot is valid.
- R2: Slot 0 issues the oldest ready entry and slot 1 issues the next oldest, whatever their classes. Sequence a is older than b when bit 7 of (a−b) mod 256 is 1, so 250 is older than 2.
- R3: At most 2 entries issue per cycle. Further ready entries wait for a later cycle. Slot 1 is valid only when slot 0 is valid.
- R4: Each of the 2 wakeup ports is compared against both source tags of every waiting entry. A wakeup in the same cycle as the insert of a consumer of that tag makes the consumer's operand ready, so it issues in the next cycle.
- R5: All scoreboard bits are ready after reset. Inserting an instruction clears the ready bit of its destination tag. A later consumer of that tag then waits for a wakeup.
- R6: An entry inserted with `in_nonspec`=1 never issues until `ev_op`=0 (release) names its thread and sequence number. A release naming another sequence number or another thread has no effect on it.
- R7: An entry of class 3 (memory) issues only after `ev_op`=1 (memory go) names it.
- R8: `ev_op`=2 (reschedule) sent to an issued entry returns it to waiting. It stays blocked until `ev_op`=3 (replay) names it, and then it issues again.
- R9: A squash removes every entry of `sq_tid` that is strictly younger than `sq_seq`, including held non-speculative ones. Older entries, the squash entry itself and the other thread's entries are unaffected.
- R10: A commit frees every entry of `cm_tid` whose sequence number is not younger than `cm_seq`. Younger entries of that thread stay.
- R11: A thread may occupy at most 8 entries (half of 16, partitioned). `in_rdy` is 0 for a thread at its limit and 0 whenever all 16 entries are occupied (`q_full`=1).
- R12: Each selection issues an entry exactly once. It is not presented again in the next cycle, and the two slots never carry the same entry.

Class encoding: 0 integer, 1 floating-point, 2 branch, 3 memory. `ev_op` encoding: 0 release, 1 memory go, 2 reschedule, 3 replay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Insert request |
| in_rdy | output | 1 | Insert accepted for thread `in_tid` |
| in_tid | input | 1 | Thread of the inserted instruction |
| in_seq | input | 8 | Sequence number |
| in_cls | input | 2 | Operation class |
| in_src0 | input | 8 | First physical source tag |
| in_src1 | input | 8 | Second physical source tag |
| in_dst | input | 8 | Physical destination tag |
| in_nonspec | input | 1 | Hold until release |
| wk_vld | input | 2 | Wakeup port valids |
| wk_tag | input | 16 | Two 8-bit wakeup tags |
| ev_vld | input | 1 | Entry event valid |
| ev_op | input | 2 | Event kind |
| ev_tid | input | 1 | Event thread |
| ev_seq | input | 8 | Event sequence number |
| sq_vld | input | 1 | Squash request |
| sq_tid | input | 1 | Squash thread |
| sq_seq | input | 8 | Youngest surviving sequence number |
| cm_vld | input | 1 | Commit request |
| cm_tid | input | 1 | Commit thread |
| cm_seq | input | 8 | Last committed sequence number |
| q_full | output | 1 | All entries occupied |
| iss_vld | output | 2 | Issue slot valids |
| iss_tid | output | 2 | Thread per slot |
| iss_seq | output | 16 | Sequence number per slot |
| iss_cls | output | 4 | Class per slot |
| iss_dst | output | 16 | Destination tag per slot |

## Verification
The checker relies on these conditions on the inputs:
- Inserts are made only while `in_rdy` is high.
- Within a thread, live sequence numbers are unique and lie within a 128-wide window.
- No insert for a thread arrives in the same cycle as a squash of that thread.
- A reschedule targets only an entry that has already issued.

The stimulus respects all of these. It commits each scenario's entries before the next scenario starts, inserts only below the per-thread limit, and always sends a reschedule at least one cycle after the entry's issue cycle.

// File: rtl/iq_pkg.sv
package iq_pkg;
    parameter int NPREG = 192;
    parameter int NTHR  = 2;
    parameter int NCLS  = 4;
    parameter int SEQW  = 8;
    localparam int TAGW = $clog2(NPREG);
    localparam int TIDW = (NTHR > 1) ? $clog2(NTHR) : 1;
    localparam int CLSW = (NCLS > 1) ? $clog2(NCLS) : 1;
    localparam logic [CLSW-1:0] CLS_MEM = CLSW'(NCLS - 1);

    typedef enum logic [1:0] {ST_FREE, ST_WAIT, ST_ISSUED} ent_st_e;
    typedef enum logic [1:0] {EV_RELEASE, EV_MEM_GO, EV_RESCHED, EV_REPLAY} ev_op_e;

    typedef struct packed {
        logic [TIDW-1:0] tid;
        logic [SEQW-1:0] seq;
        logic [CLSW-1:0] cls;
        logic [TAGW-1:0] src0;
        logic [TAGW-1:0] src1;
        logic [TAGW-1:0] dst;
        logic            s0r;
        logic            s1r;
        logic            ns_hold;
        logic            mem_ok;
        logic            mem_hold;
    } ent_t;

    // a is older than b when (a - b) wraps negative
    function automatic logic seq_older(input logic [SEQW-1:0] a, input logic [SEQW-1:0] b);
        logic [SEQW-1:0] d;
        d = a - b;
        return d[SEQW-1];
    endfunction
endpackage

// File: rtl/iq_scoreboard.sv
module iq_scoreboard import iq_pkg::*; #(
    parameter int WKN = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [WKN-1:0]            wk_vld,
    input  logic [WKN-1:0][TAGW-1:0]  wk_tag,
    input  logic                      clr_vld,
    input  logic [TAGW-1:0]           clr_tag,
    output logic [NPREG-1:0]          rdy
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy <= '1;
        end else begin
            for (int w = 0; w < WKN; w++) begin
                if (wk_vld[w]) rdy[wk_tag[w]] <= 1'b1;
            end
            // a newly recorded producer wins over a same-cycle wakeup
            if (clr_vld) rdy[clr_tag] <= 1'b0;
        end
    end
endmodule

// File: rtl/iq_oldest_pick.sv
module iq_oldest_pick import iq_pkg::*; #(
    parameter int N = 16
) (
    input  logic [N-1:0]        mask,
    input  logic [SEQW-1:0]     seq [N],
    output logic                vld,
    output logic [$clog2(N)-1:0] idx
);
    always_comb begin
        vld = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (mask[i] && (!vld || seq_older(seq[i], seq[idx]))) begin
                vld = 1'b1;
                idx = ($clog2(N))'(i);
            end
        end
    end
endmodule

// File: rtl/iq_select.sv
module iq_select import iq_pkg::*; #(
    parameter int N = 16
) (
    input  logic [N-1:0]         cand,
    input  logic [SEQW-1:0]      seq [N],
    input  logic [CLSW-1:0]      cls [N],
    output logic                 vld,
    output logic [$clog2(N)-1:0] idx
);
    localparam int IDXW = $clog2(N);
    logic [NCLS-1:0] head_v;
    logic [IDXW-1:0] head_i [NCLS];

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        logic [N-1:0] cls_mask;
        always_comb begin
            for (int i = 0; i < N; i++) cls_mask[i] = cand[i] && (cls[i] == CLSW'(c));
        end
        iq_oldest_pick #(.N(N)) pick_i (
            .mask(cls_mask), .seq(seq), .vld(head_v[c]), .idx(head_i[c])
        );
    end

    // age order among the per-class heads
    always_comb begin
        vld = 1'b0;
        idx = '0;
        for (int c = 0; c < NCLS; c++) begin
            if (head_v[c] && (!vld || seq_older(seq[head_i[c]], seq[idx]))) begin
                vld = 1'b1;
                idx = head_i[c];
            end
        end
    end
endmodule

// File: rtl/ooo_issue_queue.sv
module ooo_issue_queue import iq_pkg::*; #(
    parameter int NENT        = 16,
    parameter int IW          = 2,
    parameter int WKN         = 2,
    parameter bit PARTITIONED = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_vld,
    output logic                     in_rdy,
    input  logic [TIDW-1:0]          in_tid,
    input  logic [SEQW-1:0]          in_seq,
    input  logic [CLSW-1:0]          in_cls,
    input  logic [TAGW-1:0]          in_src0,
    input  logic [TAGW-1:0]          in_src1,
    input  logic [TAGW-1:0]          in_dst,
    input  logic                     in_nonspec,
    input  logic [WKN-1:0]           wk_vld,
    input  logic [WKN-1:0][TAGW-1:0] wk_tag,
    input  logic                     ev_vld,
    input  logic [1:0]               ev_op,
    input  logic [TIDW-1:0]          ev_tid,
    input  logic [SEQW-1:0]          ev_seq,
    input  logic                     sq_vld,
    input  logic [TIDW-1:0]          sq_tid,
    input  logic [SEQW-1:0]          sq_seq,
    input  logic                     cm_vld,
    input  logic [TIDW-1:0]          cm_tid,
    input  logic [SEQW-1:0]          cm_seq,
    output logic                     q_full,
    output logic [IW-1:0]            iss_vld,
    output logic [IW-1:0][TIDW-1:0]  iss_tid,
    output logic [IW-1:0][SEQW-1:0]  iss_seq,
    output logic [IW-1:0][CLSW-1:0]  iss_cls,
    output logic [IW-1:0][TAGW-1:0]  iss_dst
);
    localparam int IDXW = $clog2(NENT);
    localparam int CNTW = $clog2(NENT + 1);
    localparam int TMAX = PARTITIONED ? (NENT / NTHR) : NENT;

    ent_st_e          st_q  [NENT];
    ent_st_e          st_d  [NENT];
    ent_t             ent_q [NENT];
    ent_t             ent_d [NENT];
    logic [SEQW-1:0]  seq_arr [NENT];
    logic [CLSW-1:0]  cls_arr [NENT];
    logic [NENT-1:0]  rdy_vec;
    logic [NENT-1:0]  cand [IW+1];
    logic [IW-1:0]    pick_v;
    logic [IDXW-1:0]  pick_i [IW];
    logic [NENT-1:0]  issue_hit;
    logic [NPREG-1:0] sb_rdy;
    logic [CNTW-1:0]  occ [NTHR];
    logic             ins_found;
    logic [IDXW-1:0]  ins_idx;
    logic             ins_go;

    function automatic logic wake_hit(input logic [WKN-1:0] v,
                                      input logic [WKN-1:0][TAGW-1:0] tg,
                                      input logic [TAGW-1:0] t);
        logic h;
        h = 1'b0;
        for (int w = 0; w < WKN; w++) h = h | (v[w] && (tg[w] == t));
        return h;
    endfunction

    iq_scoreboard #(.WKN(WKN)) sb_i (
        .clk(clk), .rst_n(rst_n), .wk_vld(wk_vld), .wk_tag(wk_tag),
        .clr_vld(ins_go), .clr_tag(in_dst), .rdy(sb_rdy)
    );

    // candidate set and occupancy
    always_comb begin
        ins_found = 1'b0;
        ins_idx   = '0;
        for (int t = 0; t < NTHR; t++) occ[t] = '0;
        for (int i = 0; i < NENT; i++) begin
            seq_arr[i] = ent_q[i].seq;
            cls_arr[i] = ent_q[i].cls;
            rdy_vec[i] = (st_q[i] == ST_WAIT) && ent_q[i].s0r && ent_q[i].s1r &&
                         !ent_q[i].ns_hold && ent_q[i].mem_ok && !ent_q[i].mem_hold;
            if (st_q[i] != ST_FREE) begin
                occ[ent_q[i].tid] = occ[ent_q[i].tid] + CNTW'(1);
            end else if (!ins_found) begin
                ins_found = 1'b1;
                ins_idx   = IDXW'(i);
            end
        end
        q_full = !ins_found;
        in_rdy = ins_found && (occ[in_tid] < CNTW'(TMAX));
        ins_go = in_vld && in_rdy;
    end

    // one selection round per issue slot, each excluding earlier winners
    assign cand[0] = rdy_vec;
    for (genvar k = 0; k < IW; k++) begin : g_slot
        logic [NENT-1:0] win_bit;
        iq_select #(.N(NENT)) sel_i (
            .cand(cand[k]), .seq(seq_arr), .cls(cls_arr),
            .vld(pick_v[k]), .idx(pick_i[k])
        );
        assign win_bit    = pick_v[k] ? (NENT'(1) << pick_i[k]) : '0;
        assign cand[k+1]  = cand[k] & ~win_bit;
    end
    assign issue_hit = rdy_vec & ~cand[IW];

    // output process
    always_comb begin
        for (int k = 0; k < IW; k++) begin
            iss_vld[k] = pick_v[k];
            iss_tid[k] = ent_q[pick_i[k]].tid;
            iss_seq[k] = ent_q[pick_i[k]].seq;
            iss_cls[k] = ent_q[pick_i[k]].cls;
            iss_dst[k] = ent_q[pick_i[k]].dst;
        end
    end

    // per-entry next state
    always_comb begin
        for (int i = 0; i < NENT; i++) begin
            logic ev_hit;
            logic kill;
            st_d[i]  = st_q[i];
            ent_d[i] = ent_q[i];
            ev_hit = ev_vld && (ent_q[i].tid == ev_tid) && (ent_q[i].seq == ev_seq);
            kill   = (sq_vld && (ent_q[i].tid == sq_tid) && seq_older(sq_seq, ent_q[i].seq)) ||
                     (cm_vld && (ent_q[i].tid == cm_tid) && !seq_older(cm_seq, ent_q[i].seq));
            unique case (st_q[i])
                ST_FREE: begin
                    if (ins_go && (ins_idx == IDXW'(i))) begin
                        st_d[i]           = ST_WAIT;
                        ent_d[i].tid      = in_tid;
                        ent_d[i].seq      = in_seq;
                        ent_d[i].cls      = in_cls;
                        ent_d[i].src0     = in_src0;
                        ent_d[i].src1     = in_src1;
                        ent_d[i].dst      = in_dst;
                        ent_d[i].s0r      = sb_rdy[in_src0] | wake_hit(wk_vld, wk_tag, in_src0);
                        ent_d[i].s1r      = sb_rdy[in_src1] | wake_hit(wk_vld, wk_tag, in_src1);
                        ent_d[i].ns_hold  = in_nonspec;
                        ent_d[i].mem_ok   = (in_cls != CLS_MEM);
                        ent_d[i].mem_hold = 1'b0;
                    end
                end
                ST_WAIT: begin
                    if (kill) begin
                        st_d[i] = ST_FREE;
                    end else if (issue_hit[i]) begin
                        st_d[i] = ST_ISSUED;
                    end else begin
                        ent_d[i].s0r = ent_q[i].s0r | wake_hit(wk_vld, wk_tag, ent_q[i].src0);
                        ent_d[i].s1r = ent_q[i].s1r | wake_hit(wk_vld, wk_tag, ent_q[i].src1);
                        if (ev_hit) begin
                            case (ev_op_e'(ev_op))
                                EV_RELEASE: ent_d[i].ns_hold  = 1'b0;
                                EV_MEM_GO:  ent_d[i].mem_ok   = 1'b1;
                                EV_REPLAY:  ent_d[i].mem_hold = 1'b0;
                                default:    ;
                            endcase
                        end
                    end
                end
                ST_ISSUED: begin
                    if (kill) begin
                        st_d[i] = ST_FREE;
                    end else if (ev_hit && (ev_op_e'(ev_op) == EV_RESCHED)) begin
                        st_d[i]           = ST_WAIT;
                        ent_d[i].mem_hold = 1'b1;
                    end
                end
                default: st_d[i] = ST_FREE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NENT; i++) begin
                st_q[i]  <= ST_FREE;
                ent_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NENT; i++) begin
                st_q[i]  <= st_d[i];
                ent_q[i] <= ent_d[i];
            end
        end
    end
endmodule

// File: rtl/iq_checker.sv
module iq_checker import iq_pkg::*; #(
    parameter int IW = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_rdy,
    input logic                    q_full,
    input logic [IW-1:0]           iss_vld,
    input logic [IW-1:0][TIDW-1:0] iss_tid,
    input logic [IW-1:0][SEQW-1:0] iss_seq,
    input logic                    sq_vld,
    input logic [TIDW-1:0]         sq_tid,
    input logic [SEQW-1:0]         sq_seq
);
    AST_SLOT_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld[1] |-> iss_vld[0]); // R3

    AST_AGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld[0] && iss_vld[1]) |-> !seq_older(iss_seq[1], iss_seq[0])); // R2

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !in_rdy); // R11

    AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld[0] |=> !(iss_vld[0] && (iss_seq[0] == $past(iss_seq[0])) &&
                         (iss_tid[0] == $past(iss_tid[0])))); // R12

    AST_SLOTS_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld[0] && iss_vld[1]) |-> ((iss_seq[0] != iss_seq[1]) ||
                                        (iss_tid[0] != iss_tid[1]))); // R12

    AST_SQUASH_GONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sq_vld) && iss_vld[0] && (iss_tid[0] == $past(sq_tid))) |->
            !seq_older($past(sq_seq), iss_seq[0])); // R9
endmodule

bind ooo_issue_queue iq_checker #(.IW(IW)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_rdy(in_rdy), .q_full(q_full),
    .iss_vld(iss_vld), .iss_tid(iss_tid), .iss_seq(iss_seq),
    .sq_vld(sq_vld), .sq_tid(sq_tid), .sq_seq(sq_seq)
);

// File: tb/ooo_issue_queue_tb_top.sv
`timescale 1ns/1ps
module ooo_issue_queue_tb_top;
    localparam logic [1:0] OP_REL = 2'd0, OP_GO = 2'd1, OP_RES = 2'd2, OP_REP = 2'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_vld = 1'b0, in_rdy, in_tid = 1'b0, in_nonspec = 1'b0;
    logic [7:0] in_seq = '0, in_src0 = '0, in_src1 = '0, in_dst = '0;
    logic [1:0] in_cls = '0;
    logic [1:0] wk_vld = '0;
    logic [1:0][7:0] wk_tag = '0;
    logic ev_vld = 1'b0, ev_tid = 1'b0;
    logic [1:0] ev_op = '0;
    logic [7:0] ev_seq = '0;
    logic sq_vld = 1'b0, sq_tid = 1'b0, cm_vld = 1'b0, cm_tid = 1'b0;
    logic [7:0] sq_seq = '0, cm_seq = '0;
    logic q_full;
    logic [1:0] iss_vld, iss_tid;
    logic [1:0][7:0] iss_seq, iss_dst;
    logic [1:0][1:0] iss_cls;

    int nchk = 0, nerr = 0;
    logic [8:0] exp_q [$];

    always #2.5 clk = ~clk;

    ooo_issue_queue dut_i (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_rdy(in_rdy), .in_tid(in_tid),
        .in_seq(in_seq), .in_cls(in_cls), .in_src0(in_src0), .in_src1(in_src1),
        .in_dst(in_dst), .in_nonspec(in_nonspec), .wk_vld(wk_vld), .wk_tag(wk_tag),
        .ev_vld(ev_vld), .ev_op(ev_op), .ev_tid(ev_tid), .ev_seq(ev_seq),
        .sq_vld(sq_vld), .sq_tid(sq_tid), .sq_seq(sq_seq),
        .cm_vld(cm_vld), .cm_tid(cm_tid), .cm_seq(cm_seq), .q_full(q_full),
        .iss_vld(iss_vld), .iss_tid(iss_tid), .iss_seq(iss_seq),
        .iss_cls(iss_cls), .iss_dst(iss_dst)
    );

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_iss(input logic t, input logic [7:0] s);
        exp_q.push_back({t, s});
    endtask

    task automatic ins(input logic t, input logic [7:0] s, input logic [1:0] c,
                       input logic [7:0] s0, input logic [7:0] s1,
                       input logic [7:0] d, input logic ns);
        in_tid = t; in_seq = s; in_cls = c; in_src0 = s0; in_src1 = s1;
        in_dst = d; in_nonspec = ns; in_vld = 1'b1;
        step();
        in_vld = 1'b0;
    endtask

    task automatic ev(input logic [1:0] op, input logic t, input logic [7:0] s);
        ev_op = op; ev_tid = t; ev_seq = s; ev_vld = 1'b1;
        step();
        ev_vld = 1'b0;
    endtask

    task automatic wake(input logic [7:0] tag);
        wk_tag[0] = tag; wk_vld = 2'b01;
        step();
        wk_vld = 2'b00;
    endtask

    task automatic commit(input logic t, input logic [7:0] s);
        cm_tid = t; cm_seq = s; cm_vld = 1'b1;
        step();
        cm_vld = 1'b0;
    endtask

    task automatic squash(input logic t, input logic [7:0] s);
        sq_tid = t; sq_seq = s; sq_vld = 1'b1;
        step();
        sq_vld = 1'b0;
    endtask

    // monitor: every presented issue must match the next expected item
    always @(negedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < 2; k++) begin
                if (iss_vld[k]) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R12 unexpected issue seq", int'(iss_seq[k]), -1);
                    end else begin
                        logic [8:0] e;
                        e = exp_q.pop_front();
                        chk({iss_tid[k], iss_seq[k]} == e, "R2 issue order tid/seq",
                            int'({iss_tid[k], iss_seq[k]}), int'(e));
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog R12 run state", 0, 1);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        in_tid = 1'b0;
        #1;
        chk(in_rdy == 1'b1, "R1 in_rdy", in_rdy, 1);
        chk(q_full == 1'b0, "R1 q_full", q_full, 0);
        chk(iss_vld == 2'b00, "R1 iss_vld", iss_vld, 0);

        // oldest-first across classes, width limit, scoreboard clear
        expect_iss(0, 8'd1);
        ins(0, 8'd1, 2'd0, 8'd0, 8'd0, 8'd50, 0);
        ins(0, 8'd7, 2'd0, 8'd50, 8'd0, 8'd150, 0);
        ins(0, 8'd5, 2'd1, 8'd50, 8'd0, 8'd150, 0);
        ins(0, 8'd6, 2'd2, 8'd0, 8'd50, 8'd150, 0);
        chk(iss_vld == 2'b00, "R5 consumers wait on cleared tag", iss_vld, 0);
        expect_iss(0, 8'd5); expect_iss(0, 8'd6); expect_iss(0, 8'd7);
        wake(8'd50);
        chk(iss_vld == 2'b11, "R3 two slots used", iss_vld, 3);
        chk(iss_seq[0] == 8'd5 && iss_seq[1] == 8'd6, "R2 slot order", iss_seq[0], 5);
        step();
        chk(iss_vld == 2'b01 && iss_seq[0] == 8'd7, "R3 leftover next cycle", iss_seq[0], 7);
        commit(0, 8'd9);

        // same-cycle wakeup on port 1 at insert
        expect_iss(0, 8'd10);
        ins(0, 8'd10, 2'd0, 8'd0, 8'd0, 8'd60, 0);
        expect_iss(0, 8'd11);
        wk_tag[1] = 8'd60; wk_vld = 2'b10;
        ins(0, 8'd11, 2'd0, 8'd60, 8'd0, 8'd150, 0);
        wk_vld = 2'b00;
        chk(iss_vld[0] && iss_seq[0] == 8'd11, "R4 insert bypass wakeup", iss_seq[0], 11);
        commit(0, 8'd19);

        // non-speculative hold
        ins(0, 8'd20, 2'd0, 8'd0, 8'd0, 8'd150, 1);
        step();
        chk(iss_vld == 2'b00, "R6 held", iss_vld, 0);
        ev(OP_REL, 0, 8'd21);
        chk(iss_vld == 2'b00, "R6 wrong seq ignored", iss_vld, 0);
        ev(OP_REL, 1, 8'd20);
        chk(iss_vld == 2'b00, "R6 wrong thread ignored", iss_vld, 0);
        expect_iss(0, 8'd20);
        ev(OP_REL, 0, 8'd20);
        chk(iss_vld[0] && iss_seq[0] == 8'd20, "R6 released", iss_seq[0], 20);
        commit(0, 8'd29);

        // memory go, reschedule, replay
        ins(0, 8'd30, 2'd3, 8'd0, 8'd0, 8'd150, 0);
        chk(iss_vld == 2'b00, "R7 memory waits", iss_vld, 0);
        expect_iss(0, 8'd30);
        ev(OP_GO, 0, 8'd30);
        chk(iss_vld[0] && iss_seq[0] == 8'd30, "R7 memory go", iss_seq[0], 30);
        step();
        ev(OP_RES, 0, 8'd30);
        chk(iss_vld == 2'b00, "R8 rescheduled blocked", iss_vld, 0);
        step();
        chk(iss_vld == 2'b00, "R8 still blocked", iss_vld, 0);
        expect_iss(0, 8'd30);
        ev(OP_REP, 0, 8'd30);
        chk(iss_vld[0] && iss_seq[0] == 8'd30, "R8 replay issues", iss_seq[0], 30);
        commit(0, 8'd39);

        // per-thread squash
        ins(1, 8'd40, 2'd0, 8'd0, 8'd0, 8'd150, 1);
        ins(1, 8'd41, 2'd0, 8'd0, 8'd0, 8'd150, 1);
        ins(1, 8'd42, 2'd0, 8'd0, 8'd0, 8'd150, 1);
        ins(0, 8'd45, 2'd0, 8'd0, 8'd0, 8'd150, 1);
        squash(1, 8'd40);
        ev(OP_REL, 1, 8'd41);
        chk(iss_vld == 2'b00, "R9 squashed 41 gone", iss_vld, 0);
        ev(OP_REL, 1, 8'd42);
        chk(iss_vld == 2'b00, "R9 squashed 42 gone", iss_vld, 0);
        expect_iss(1, 8'd40);
        ev(OP_REL, 1, 8'd40);
        chk(iss_vld[0] && iss_tid[0] && iss_seq[0] == 8'd40, "R9 squash point kept", iss_seq[0], 40);
        expect_iss(0, 8'd45);
        ev(OP_REL, 0, 8'd45);
        chk(iss_vld[0] && !iss_tid[0] && iss_seq[0] == 8'd45, "R9 other thread kept", iss_seq[0], 45);
        commit(0, 8'd50);
        commit(1, 8'd50);

        // occupancy limits and commit
        for (int s = 100; s < 108; s++) ins(0, 8'(s), 2'd0, 8'd0, 8'd0, 8'd150, 1);
        in_tid = 0; #1;
        chk(in_rdy == 1'b0, "R11 thread 0 at limit", in_rdy, 0);
        in_tid = 1; #1;
        chk(in_rdy == 1'b1, "R11 thread 1 still open", in_rdy, 1);
        for (int s = 100; s < 108; s++) ins(1, 8'(s), 2'd0, 8'd0, 8'd0, 8'd150, 1);
        in_tid = 1; #1;
        chk(q_full == 1'b1, "R11 full flag", q_full, 1);
        chk(in_rdy == 1'b0, "R11 full blocks insert", in_rdy, 0);
        commit(0, 8'd103);
        in_tid = 0; #1;
        chk(q_full == 1'b0, "R10 commit frees", q_full, 0);
        chk(in_rdy == 1'b1, "R10 thread 0 reopened", in_rdy, 1);
        for (int s = 108; s < 112; s++) ins(0, 8'(s), 2'd0, 8'd0, 8'd0, 8'd150, 1);
        in_tid = 0; #1;
        chk(in_rdy == 1'b0, "R10 exactly four freed", in_rdy, 0);
        ev(OP_REL, 0, 8'd100);
        chk(iss_vld == 2'b00, "R10 committed entry gone", iss_vld, 0);
        expect_iss(0, 8'd104);
        ev(OP_REL, 0, 8'd104);
        chk(iss_vld[0] && iss_seq[0] == 8'd104, "R10 younger entry kept", iss_seq[0], 104);
        commit(0, 8'd120);
        commit(1, 8'd120);

        // wrap-aware age
        expect_iss(0, 8'd248);
        ins(0, 8'd248, 2'd0, 8'd0, 8'd0, 8'd70, 0);
        ins(0, 8'd2, 2'd0, 8'd70, 8'd0, 8'd150, 0);
        ins(0, 8'd250, 2'd1, 8'd70, 8'd0, 8'd150, 0);
        expect_iss(0, 8'd250); expect_iss(0, 8'd2);
        wake(8'd70);
        chk(iss_vld == 2'b11 && iss_seq[0] == 8'd250 && iss_seq[1] == 8'd2,
            "R2 wrap order", iss_seq[0], 250);
        commit(0, 8'd2);
        in_tid = 0; #1;
        chk(in_rdy == 1'b1 && q_full == 1'b0, "R10 wrap commit", q_full, 0);

        repeat (3) step();
        chk(exp_q.size() == 0, "R12 all expected issues seen", exp_q.size(), 0);
        report();
    end
endmodule